// File: doc/BRIEF.md
# Page-Mode Nonvolatile Write Sequencer

This block is the device-side control for a byte-wide nonvolatile memory. A host drives a parallel bus with active-low chip enable, write enable and output enable, an address and a data byte. The block brings those pins into its clock domain through two-flop synchronisers. It then collects byte loads into a page buffer. After the bus has been quiet for long enough, it runs an internal program cycle with no further command from the host.

Each page holds 2**PAGE_W bytes (64 by default). The page number comes from the first load of a burst and stays fixed for the rest of that burst. A load that starts too long after the previous one begins a fresh burst. An open-drain style busy indication is pulled from the first load until the program cycle ends. An active-low inhibit input blocks reads and loads, and it cuts short a burst or a program cycle that is in progress.

All windows are counted in clock cycles, derived from a clock-rate parameter in MHz and durations in microseconds. The memory array is a plain synchronous RAM model.

Top module: `pgwr_seq`

## Requirements
- R1: The array holds 2**ADDR_W bytes. Address bits [PAGE_W-1:0] pick the byte inside a page, and bits [ADDR_W-1:PAGE_W] pick the page.
- R2: A byte load is a strobe in which chip enable and write enable are both low, output enable is high and inhibit_n is high. The address is taken when the strobe begins (the later of the two falls). The data is taken when the strobe ends (the earlier of the two rises).
- R3: The page bits are taken from the first load of a burst. Later loads in the same burst use their own byte-offset bits but the first load's page bits.
- R4: A load that starts LOAD_WIN_US*CLK_MHZ cycles or more after the previous load started opens a new burst. Bytes loaded earlier and not yet programmed are discarded.
- R5: After AUTO_US*CLK_MHZ cycles without a strobe following the last data capture, the program cycle starts by itself. It runs for PROG_US*CLK_MHZ cycles and only then writes the loaded bytes. Reads taken before that return the old contents.
- R6: Bytes of the page that were not loaded in the burst keep their earlier array contents.
- R7: busy_pull is 1 from the start of the first load of a burst until the program cycle has written the page. Otherwise it is 0.
- R8: While inhibit_n is low, rd_vld stays 0 and strobes are not taken as loads.
- R9: inhibit_n going low during a burst or a program cycle abandons it: busy_pull returns to 0 and the array keeps its old contents.
- R10: A write-enable strobe with chip enable high (standby), or with output enable low, loads nothing and starts no program cycle.
- R11: Strobes that start while a program cycle runs are ignored. They neither change the array nor start another cycle.
- R12: With chip enable and output enable low, write enable high and inhibit_n high, rd_vld is 1 and rd_data is the array byte at addr, a few cycles after the inputs settle.
- R13: After reset, busy_pull and rd_vld are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| inhibit_n | input | 1 | Read/program inhibit, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data |
| rd_vld | output | 1 | Read data valid |
| busy_pull | output | 1 | 1 while the busy line is pulled low |

## Verification
The page function is exercised with several load patterns, each aimed at one way the design can go wrong:
- A lone byte shows the auto-start timing and that the write happens at the end of the program cycle.
- A fast multi-byte burst that includes a load with foreign page bits shows whether the page is frozen.
- A single-byte rewrite of a page loaded earlier shows whether unloaded bytes are preserved.
- Two loads spaced beyond the window show whether the burst is restarted rather than merged.

Strobes made in standby, with output enable low, under inhibit, and during a running cycle are each followed by a read-back. This separates a block that ignores them from one that programs stale or wrong bytes.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2,
    ST_BURN = 2'd3
  } pgwr_state_e;
endpackage

// File: rtl/pgwr_sync.sv
module pgwr_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign d_out = sync_q;
endmodule

// File: rtl/pgwr_strobe.sv
module pgwr_strobe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic              inh_s,
  input  logic [DATA_W-1:0] din_s,
  output logic              strobe_on,
  output logic              ld_start,
  output logic              ld_commit,
  output logic [DATA_W-1:0] ld_data,
  output logic              rd_en
);
  logic              act_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;

  // write strobe: both enables low, output disabled, not inhibited
  assign strobe_on = ~ce_s & ~we_s & oe_s & inh_s;
  // later falling edge opens the strobe
  assign ld_start  = strobe_on & ~act_q;
  // first rising edge of ce/we closes it; other exits are not loads
  assign ld_commit = act_q & ~strobe_on & (ce_s | we_s) & oe_s & inh_s;
  assign rd_en     = ~ce_s & ~oe_s & we_s & inh_s;

  always_comb begin
    data_d = data_q;
    if (strobe_on) data_d = din_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      data_q <= '0;
    end else begin
      act_q  <= strobe_on;
      data_q <= data_d;
    end
  end

  assign ld_data = data_q;
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  vld_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && (wr_off == PAGE_W'(g))) mem_q[g] <= wr_data;
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (clr)   vld_d = '0;
    if (wr_en) vld_d[wr_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_data = mem_q[rd_off];
  assign rd_vld  = vld_q[rd_off];
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
    rd_data <= mem_q[rd_addr];
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 6,
  parameter int WIN_CYC  = 3750,
  parameter int IDLE_CYC = 12500,
  parameter int PROG_CYC = 1250000,
  parameter int CNT_W    = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_start,
  input  logic                     ld_commit,
  input  logic                     strobe_on,
  input  logic                     inh_s,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic                     buf_vld_at,
  output pgwr_state_e              st,
  output logic                     new_pg,
  output logic                     buf_clr,
  output logic                     buf_wr,
  output logic [PAGE_W-1:0]        buf_off,
  output logic [PAGE_W-1:0]        burn_idx,
  output logic [ADDR_W-PAGE_W-1:0] page_q,
  output logic                     arr_we,
  output logic [CNT_W-1:0]         prog_cnt
);
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam logic [CNT_W-1:0]  WIN_LIM  = CNT_W'(WIN_CYC);
  localparam logic [CNT_W-1:0]  IDLE_LIM = CNT_W'(IDLE_CYC);
  localparam logic [CNT_W-1:0]  PROG_END = CNT_W'(PROG_CYC - 1);
  localparam logic [PAGE_W-1:0] IDX_END  = '1;

  pgwr_state_e       st_q, st_d;
  logic [ROW_W-1:0]  page_d;
  logic [ROW_W-1:0]  page_r;
  logic [PAGE_W-1:0] off_q, off_d;
  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  win_q, win_d;
  logic [CNT_W-1:0]  idle_q, idle_d;
  logic [CNT_W-1:0]  prog_q, prog_d;
  logic [PAGE_W-1:0] idx_q, idx_d;
  logic              start_ok;
  logic              win_exp;

  assign win_exp  = (win_q >= WIN_LIM);
  assign start_ok = ld_start && ((st_q == ST_IDLE) || (st_q == ST_LOAD));

  always_comb begin
    st_d    = st_q;
    page_d  = page_r;
    off_d   = off_q;
    pend_d  = pend_q;
    win_d   = win_q;
    idle_d  = idle_q;
    prog_d  = prog_q;
    idx_d   = idx_q;
    arr_we  = 1'b0;
    new_pg  = start_ok && ((st_q == ST_IDLE) || win_exp);
    buf_wr  = ld_commit && pend_q && (st_q == ST_LOAD);

    if (win_q != WIN_LIM) win_d = win_q + 1'b1;

    unique case (st_q)
      ST_IDLE: begin
        if (new_pg) begin
          st_d   = ST_LOAD;
          page_d = ld_addr[ADDR_W-1:PAGE_W];
          off_d  = ld_addr[PAGE_W-1:0];
          pend_d = 1'b1;
          win_d  = '0;
          idle_d = '0;
        end
      end
      ST_LOAD: begin
        if (!inh_s) begin
          st_d   = ST_IDLE;
          pend_d = 1'b0;
        end else begin
          if (start_ok) begin
            off_d  = ld_addr[PAGE_W-1:0];
            pend_d = 1'b1;
            win_d  = '0;
            if (new_pg) page_d = ld_addr[ADDR_W-1:PAGE_W];
          end
          if (buf_wr) pend_d = 1'b0;
          if (strobe_on || buf_wr || start_ok) idle_d = '0;
          else if (idle_q != IDLE_LIM)          idle_d = idle_q + 1'b1;
          if (!strobe_on && !pend_q && (idle_q == IDLE_LIM)) begin
            st_d   = ST_PROG;
            prog_d = '0;
          end
        end
      end
      ST_PROG: begin
        if (!inh_s) begin
          st_d = ST_IDLE;
        end else if (prog_q == PROG_END) begin
          st_d  = ST_BURN;
          idx_d = '0;
        end else begin
          prog_d = prog_q + 1'b1;
        end
      end
      ST_BURN: begin
        if (!inh_s) begin
          st_d = ST_IDLE;
        end else begin
          arr_we = buf_vld_at;
          if (idx_q == IDX_END) st_d = ST_IDLE;
          else                  idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_r <= '0;
      off_q  <= '0;
      pend_q <= 1'b0;
      win_q  <= '0;
      idle_q <= '0;
      prog_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      page_r <= page_d;
      off_q  <= off_d;
      pend_q <= pend_d;
      win_q  <= win_d;
      idle_q <= idle_d;
      prog_q <= prog_d;
      idx_q  <= idx_d;
    end
  end

  assign st       = st_q;
  assign buf_clr  = new_pg;
  assign buf_off  = off_q;
  assign burn_idx = idx_q;
  assign page_q   = page_r;
  assign prog_cnt = prog_q;
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 6,
  parameter int CLK_MHZ    = 125,
  parameter int LOAD_WIN_US = 30,
  parameter int AUTO_US    = 100,
  parameter int PROG_US    = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              inhibit_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              busy_pull
);
  localparam int ROW_W    = ADDR_W - PAGE_W;
  localparam int WIN_CYC  = CLK_MHZ * LOAD_WIN_US;
  localparam int IDLE_CYC = CLK_MHZ * AUTO_US;
  localparam int PROG_CYC = CLK_MHZ * PROG_US;
  localparam int MAX_CYC  = (PROG_CYC > IDLE_CYC) ?
                            ((PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC) :
                            ((IDLE_CYC > WIN_CYC) ? IDLE_CYC : WIN_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic              ce_s, we_s, oe_s, inh_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              strobe_on, ld_start, ld_commit, rd_en;
  logic [DATA_W-1:0] ld_data;
  pgwr_state_e       st;
  logic              new_pg, buf_clr, buf_wr, arr_we, buf_vld_at;
  logic [PAGE_W-1:0] buf_off, burn_idx;
  logic [ROW_W-1:0]  page_q;
  logic [CNT_W-1:0]  prog_cnt;
  logic [DATA_W-1:0] buf_rd;
  logic              rd_vld_q, rd_vld_d;

  pgwr_sync #(.W(4), .RST_VAL(4'b1110)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d_in({ce_n, we_n, oe_n, inhibit_n}),
    .d_out({ce_s, we_s, oe_s, inh_s})
  );

  pgwr_sync #(.W(ADDR_W + DATA_W), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n),
    .d_in({addr, din}),
    .d_out({addr_s, din_s})
  );

  pgwr_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s), .inh_s(inh_s),
    .din_s(din_s),
    .strobe_on(strobe_on), .ld_start(ld_start), .ld_commit(ld_commit),
    .ld_data(ld_data), .rd_en(rd_en)
  );

  pgwr_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_CYC(WIN_CYC),
    .IDLE_CYC(IDLE_CYC), .PROG_CYC(PROG_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ld_start(ld_start), .ld_commit(ld_commit), .strobe_on(strobe_on),
    .inh_s(inh_s), .ld_addr(addr_s), .buf_vld_at(buf_vld_at),
    .st(st), .new_pg(new_pg), .buf_clr(buf_clr), .buf_wr(buf_wr),
    .buf_off(buf_off), .burn_idx(burn_idx), .page_q(page_q),
    .arr_we(arr_we), .prog_cnt(prog_cnt)
  );

  pgwr_pagebuf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n),
    .clr(buf_clr), .wr_en(buf_wr), .wr_off(buf_off), .wr_data(ld_data),
    .rd_off(burn_idx), .rd_data(buf_rd), .rd_vld(buf_vld_at)
  );

  pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk),
    .wr_en(arr_we), .wr_addr({page_q, burn_idx}), .wr_data(buf_rd),
    .rd_addr(addr_s), .rd_data(rd_data)
  );

  always_comb rd_vld_d = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= rd_vld_d;
  end

  assign rd_vld    = rd_vld_q;
  assign busy_pull = (st != ST_IDLE);
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk
  import pgwr_pkg::*;
#(
  parameter int PROG_CYC = 16,
  parameter int CNT_W    = 5,
  parameter int ROW_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inhibit_n,
  input logic             busy_pull,
  input logic             rd_vld,
  input logic             arr_we,
  input pgwr_state_e      st,
  input logic             new_pg,
  input logic [ROW_W-1:0] page_q,
  input logic [CNT_W-1:0] prog_cnt
);
  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end

  assert_inhibit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4 && !inhibit_n && $past(!inhibit_n) && $past(!inhibit_n, 2)
     && $past(!inhibit_n, 3)) |-> (!rd_vld && !busy_pull));

  assert_write_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy_pull);

  assert_prog_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG) |-> (prog_cnt < CNT_W'(PROG_CYC)));

  assert_prog_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd1 && st == ST_PROG && $past(st) != ST_PROG) |-> ($past(st) == ST_LOAD));

  assert_page_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd1 && st == ST_LOAD && $past(st) == ST_LOAD && !$past(new_pg))
      |-> $stable(page_q));
endmodule

bind pgwr_seq pgwr_seq_chk #(
  .PROG_CYC(PROG_CYC), .CNT_W(CNT_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit_n(inhibit_n), .busy_pull(busy_pull),
  .rd_vld(rd_vld), .arr_we(arr_we), .st(st), .new_pg(new_pg),
  .page_q(page_q), .prog_cnt(prog_cnt)
);

// File: tb/pgwr_seq_tb_top.sv
module pgwr_seq_tb_top;
  localparam int AW = 13;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          ce_n, we_n, oe_n, inhibit_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] rd_data;
  logic          rd_vld;
  logic          busy_pull;

  int n_chk;
  int n_err;

  pgwr_seq #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_W(6), .CLK_MHZ(1),
    .LOAD_WIN_US(30), .AUTO_US(100), .PROG_US(300)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .inhibit_n(inhibit_n), .addr(addr), .din(din),
    .rd_data(rd_data), .rd_vld(rd_vld), .busy_pull(busy_pull)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] loc(input int page, input int off);
    return AW'(page * 64 + off);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    cyc(3);
    we_n = 1'b1; ce_n = 1'b1;
    cyc(2);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    cyc(6);
    chk(rd_vld === 1'b1, "R12 rd_vld", int'(rd_vld), 1);
    chk(rd_data === exp, req, int'(rd_data), int'(exp));
    oe_n = 1'b1; ce_n = 1'b1;
    cyc(2);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1200; i++) begin
      if (!busy_pull) break;
      @(negedge clk);
    end
    cyc(4);
  endtask

  task automatic t_reset();
    chk(busy_pull === 1'b0, "R13 busy after reset", int'(busy_pull), 0);
    chk(rd_vld === 1'b0, "R13 rd_vld after reset", int'(rd_vld), 0);
  endtask

  task automatic t_single();
    load(loc(0, 5), 8'hA5);
    cyc(3);
    chk(busy_pull === 1'b1, "R7 busy after first load", int'(busy_pull), 1);
    cyc(300);
    chk(busy_pull === 1'b1, "R7 busy during program", int'(busy_pull), 1);
    cyc(200);
    chk(busy_pull === 1'b0, "R7 busy released", int'(busy_pull), 0);
    read_chk(loc(0, 5), 8'hA5, "R2 R1 single byte");
  endtask

  task automatic t_page_frozen();
    for (int i = 0; i < 8; i++) load(loc(3, i), DW'(8'h10 + i));
    load(loc(9, 8), 8'h77);
    wait_idle();
    for (int i = 0; i < 8; i++) read_chk(loc(3, i), DW'(8'h10 + i), "R5 page burst");
    read_chk(loc(3, 8), 8'h77, "R3 frozen page bits");
  endtask

  task automatic t_partial();
    load(loc(3, 2), 8'hC2);
    wait_idle();
    read_chk(loc(3, 1), 8'h11, "R6 neighbour below kept");
    read_chk(loc(3, 2), 8'hC2, "R6 loaded byte");
    read_chk(loc(3, 3), 8'h13, "R6 neighbour above kept");
  endtask

  task automatic t_window();
    load(loc(5, 0), 8'h55);
    load(loc(5, 1), 8'h56);
    wait_idle();
    load(loc(5, 0), 8'hE0);
    cyc(40);
    load(loc(6, 1), 8'h61);
    wait_idle();
    read_chk(loc(5, 0), 8'h55, "R4 stale byte discarded");
    read_chk(loc(5, 1), 8'h56, "R4 old page untouched");
    read_chk(loc(6, 1), 8'h61, "R4 new page taken");
  endtask

  task automatic t_commit_late();
    load(loc(7, 0), 8'h70);
    load(loc(7, 1), 8'h7A);
    wait_idle();
    load(loc(7, 0), 8'h71);
    cyc(200);
    read_chk(loc(7, 0), 8'h70, "R5 old data during program");
    chk(busy_pull === 1'b1, "R7 busy mid program", int'(busy_pull), 1);
    wait_idle();
    read_chk(loc(7, 0), 8'h71, "R5 data after program");
  endtask

  task automatic t_abort();
    load(loc(7, 0), 8'h99);
    cyc(150);
    inhibit_n = 1'b0;
    cyc(8);
    chk(busy_pull === 1'b0, "R9 busy after abort", int'(busy_pull), 0);
    ce_n = 1'b0; oe_n = 1'b0; addr = loc(7, 0);
    cyc(6);
    chk(rd_vld === 1'b0, "R8 read blocked", int'(rd_vld), 0);
    ce_n = 1'b1; oe_n = 1'b1;
    inhibit_n = 1'b1;
    cyc(600);
    chk(busy_pull === 1'b0, "R9 no resume", int'(busy_pull), 0);
    read_chk(loc(7, 0), 8'h71, "R9 array unchanged");
  endtask

  task automatic t_inhibit_load();
    inhibit_n = 1'b0;
    cyc(4);
    load(loc(7, 0), 8'h33);
    cyc(4);
    chk(busy_pull === 1'b0, "R8 no load when inhibited", int'(busy_pull), 0);
    inhibit_n = 1'b1;
    cyc(600);
    read_chk(loc(7, 0), 8'h71, "R8 array unchanged");
  endtask

  task automatic t_standby();
    @(negedge clk);
    addr = loc(7, 0); din = 8'h44; ce_n = 1'b1; we_n = 1'b0;
    cyc(3);
    we_n = 1'b1;
    cyc(4);
    chk(busy_pull === 1'b0, "R10 standby strobe", int'(busy_pull), 0);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; din = 8'h45;
    cyc(3);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    cyc(4);
    chk(busy_pull === 1'b0, "R10 output-enable strobe", int'(busy_pull), 0);
    cyc(600);
    read_chk(loc(7, 0), 8'h71, "R10 array unchanged");
  endtask

  task automatic t_during_prog();
    load(loc(7, 0), 8'h42);
    cyc(150);
    load(loc(7, 1), 8'hEE);
    wait_idle();
    cyc(200);
    chk(busy_pull === 1'b0, "R11 no second cycle", int'(busy_pull), 0);
    read_chk(loc(7, 0), 8'h42, "R11 first page written");
    read_chk(loc(7, 1), 8'h7A, "R11 late load ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; inhibit_n = 1'b1;
    addr = '0; din = '0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_single();
    t_page_frozen();
    t_partial();
    t_window();
    t_commit_late();
    t_abort();
    t_inhibit_load();
    t_standby();
    t_during_prog();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule